// File: doc/BRIEF.md
# Fuse Array Access Controller

This block is the register front end for a one-time-programmable fuse array of 8 KiB, addressed per byte. Software uses a 32-bit register bus to switch the array's power, set a 13-bit byte address through a high and a low address register, choose a function (read or program), and start it with a go bit. The controller then runs the access for a fixed number of cycles and reports the outcome in a result register.

Fuses can only go from 0 to 1. A program operation ORs its data byte into the stored byte, so no stored 1 ever returns to 0. The address space is split into equal regions, and two parameter masks mark regions as read-locked or program-locked. An access to a locked region does not touch the array and raises a flag that names the kind of denial. A go issued while the array is powered down or still settling raises a generic fail flag and does nothing else. The array is a behavioural model. It is stored as 32-bit words so that elaboration stays small.

Top module: `otpc_top`

## Requirements
- R1: After reset, power register (offset 0x00) reads 1 (powered down), and status (0x30), result (0x2C), go (0x28) and read data (0x18) all read 0.
- R2: Writing bit 0 = 0 to 0x00 while it is 1 sets status bit 1 (pump settling) for exactly SETTLE_CYC cycles; writing bit 0 = 1 powers down and clears settling at once.
- R3: Writing 1 to bit 0 of 0x28 makes it read 1 until the next clock edge accepts the command; it then reads 0 and status bit 0 (busy) stays high for exactly BUSY_CYC cycles.
- R4: A read (function register 0x20 = 1) of an unlocked byte clears the result and puts the byte in bits 7:0 of 0x18, with bits 31:8 zero.
- R5: A program (0x20 = 2, program-mode 0x14 bit 0 = 1, data in 0x10 bits 7:0) ORs the data byte into the stored byte; a data byte of 0 leaves the byte unchanged.
- R6: The byte address is {0x04[7:0], 0x08[7:0]} truncated to 13 bits; bits 7:5 of 0x04 have no effect.
- R7: A read in a region whose bit is set in RD_LOCK sets result bit 3 only and leaves 0x18 unchanged.
- R8: A program in a region whose bit is set in WR_LOCK sets result bit 2 only and leaves the array unchanged.
- R9: A go while the array is powered down or settling sets result bit 0 only and performs no access.
- R10: Result bits clear when each new command is accepted; at most one result bit is set.
- R11: A function value of 0 or 3, or a program with 0x14 bit 0 = 0, sets result bit 0 and performs no access.
- R12: A go written while a command is pending or busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |

## Verification
The bench builds the controller with SETTLE_CYC = 6 and BUSY_CYC = 3. These short windows let it count the settle period and the busy period to the exact edge, and they leave room to fire a second go in the middle of an operation. RD_LOCK = 0x80 and WR_LOCK = 0x40 lock reading in the top eighth of the array and programming in the eighth below it. A program into the read-locked region therefore succeeds, while reading it back is refused, so the two locks are shown to be independent. Both lock flags and the write-protect behaviour are then checked through normal reads.

// File: rtl/otpc_pkg.sv
package otpc_pkg;

    localparam logic [7:0] OFS_PWR  = 8'h00;
    localparam logic [7:0] OFS_AHI  = 8'h04;
    localparam logic [7:0] OFS_ALO  = 8'h08;
    localparam logic [7:0] OFS_PDAT = 8'h10;
    localparam logic [7:0] OFS_PMOD = 8'h14;
    localparam logic [7:0] OFS_RDAT = 8'h18;
    localparam logic [7:0] OFS_FUNC = 8'h20;
    localparam logic [7:0] OFS_GO   = 8'h28;
    localparam logic [7:0] OFS_RES  = 8'h2C;
    localparam logic [7:0] OFS_STAT = 8'h30;

    localparam logic [1:0] FN_READ = 2'b01;
    localparam logic [1:0] FN_PROG = 2'b10;

    typedef enum logic [2:0] {
        OP_READ,
        OP_PROG,
        OP_FAIL,
        OP_RD_DENY,
        OP_WR_DENY
    } op_e;

    typedef struct packed {
        logic rd_deny;
        logic wr_deny;
        logic fail;
    } verdict_t;

    function automatic verdict_t verdict_of(op_e op);
        verdict_t v;
        v.rd_deny = (op == OP_RD_DENY);
        v.wr_deny = (op == OP_WR_DENY);
        v.fail    = (op == OP_FAIL);
        return v;
    endfunction

    function automatic logic [31:0] pack_verdict(verdict_t v);
        return {28'd0, v.rd_deny, v.wr_deny, 1'b0, v.fail};
    endfunction

endpackage

// File: rtl/otpc_power.sv
module otpc_power #(
    parameter int SETTLE_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_i,
    input  logic pd_i,
    output logic pd_o,
    output logic settling_o
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);

    logic             pd_q;
    logic             settle_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pd_q     <= 1'b1;
            settle_q <= 1'b0;
            cnt_q    <= '0;
        end else if (wr_i) begin
            pd_q <= pd_i;
            if (pd_i) begin
                settle_q <= 1'b0;
            end else if (pd_q) begin
                settle_q <= 1'b1;
                cnt_q    <= CNT_W'(SETTLE_CYC - 1);
            end
        end else if (settle_q) begin
            if (cnt_q == '0) settle_q <= 1'b0;
            else             cnt_q    <= cnt_q - 1'b1;
        end
    end

    assign pd_o       = pd_q;
    assign settling_o = settle_q;
endmodule

// File: rtl/otpc_seq.sv
module otpc_seq
    import otpc_pkg::*;
#(
    parameter int                   ADDR_W      = 13,
    parameter int                   NUM_REGIONS = 8,
    parameter logic [NUM_REGIONS-1:0] RD_LOCK   = '0,
    parameter logic [NUM_REGIONS-1:0] WR_LOCK   = '0,
    parameter int                   BUSY_CYC    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_wr_i,
    input  logic              pwr_ok_i,
    input  logic [1:0]        func_i,
    input  logic              byte_mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        pdata_i,
    input  logic [7:0]        arr_rbyte_i,
    output logic              go_pend_o,
    output logic              busy_o,
    output verdict_t          verdict_o,
    output logic [7:0]        rbyte_o,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic              arr_we_o,
    output logic [7:0]        arr_wbyte_o
);
    localparam int RGN_W = $clog2(NUM_REGIONS);
    localparam int CNT_W = $clog2(BUSY_CYC + 1);

    logic              go_q, busy_q;
    logic [CNT_W-1:0]  cnt_q;
    op_e               op_q, op_d;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q, rbyte_q;
    verdict_t          verdict_q;
    logic [RGN_W-1:0]  rgn;
    logic              accept, finish;

    assign rgn    = addr_i[ADDR_W-1 -: RGN_W];
    assign accept = go_q && !busy_q;
    assign finish = busy_q && (cnt_q == '0);

    always_comb begin
        op_d = OP_FAIL;
        if (pwr_ok_i) begin
            case (func_i)
                FN_READ: op_d = RD_LOCK[rgn] ? OP_RD_DENY : OP_READ;
                FN_PROG: begin
                    if (!byte_mode_i)      op_d = OP_FAIL;
                    else if (WR_LOCK[rgn]) op_d = OP_WR_DENY;
                    else                   op_d = OP_PROG;
                end
                default: op_d = OP_FAIL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            go_q      <= 1'b0;
            busy_q    <= 1'b0;
            cnt_q     <= '0;
            op_q      <= OP_FAIL;
            addr_q    <= '0;
            data_q    <= '0;
            rbyte_q   <= '0;
            verdict_q <= '0;
        end else begin
            if (accept)                  go_q <= 1'b0;
            else if (go_wr_i && !busy_q) go_q <= 1'b1;

            if (accept) begin
                busy_q    <= 1'b1;
                cnt_q     <= CNT_W'(BUSY_CYC - 1);
                op_q      <= op_d;
                addr_q    <= addr_i;
                data_q    <= pdata_i;
                verdict_q <= '0;
            end else if (busy_q) begin
                if (finish) begin
                    busy_q    <= 1'b0;
                    verdict_q <= verdict_of(op_q);
                    if (op_q == OP_READ) rbyte_q <= arr_rbyte_i;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign go_pend_o   = go_q;
    assign busy_o      = busy_q;
    assign verdict_o   = verdict_q;
    assign rbyte_o     = rbyte_q;
    assign arr_addr_o  = addr_q;
    assign arr_we_o    = finish && (op_q == OP_PROG);
    assign arr_wbyte_o = data_q;
endmodule

// File: rtl/otpc_array.sv
module otpc_array #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [7:0]        wbyte_i,
    output logic [7:0]        rbyte_o
);
    localparam int WORDS  = (1 << ADDR_W) / 4;
    localparam int WORD_W = ADDR_W - 2;

    logic [31:0]       mem [WORDS];
    logic [WORD_W-1:0] widx;
    logic [1:0]        lane;

    assign widx    = addr_i[ADDR_W-1:2];
    assign lane    = addr_i[1:0];
    assign rbyte_o = mem[widx][8*lane +: 8];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[w] <= '0;
            end else if (we_i && widx == WORD_W'(w)) begin
                mem[w][8*lane +: 8] <= mem[w][8*lane +: 8] | wbyte_i;
            end
        end
    end
endmodule

// File: rtl/otpc_top.sv
module otpc_top
    import otpc_pkg::*;
#(
    parameter int                     ADDR_W      = 13,
    parameter int                     NUM_REGIONS = 8,
    parameter logic [NUM_REGIONS-1:0] RD_LOCK     = 8'h80,
    parameter logic [NUM_REGIONS-1:0] WR_LOCK     = 8'h40,
    parameter int                     SETTLE_CYC  = 16,
    parameter int                     BUSY_CYC    = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);
    logic [7:0]        ahi_q, alo_q, pdat_q;
    logic              pmode_q;
    logic [1:0]        func_q;
    logic              pd, settling, go_pend, busy, arr_we;
    verdict_t          verdict;
    logic [7:0]        rbyte, arr_rbyte, arr_wbyte;
    logic [ADDR_W-1:0] arr_addr, req_addr;
    logic              wr_pwr, wr_go;

    assign wr_pwr   = bus_wr && (bus_addr == OFS_PWR);
    assign wr_go    = bus_wr && (bus_addr == OFS_GO) && bus_wdata[0];
    assign req_addr = ADDR_W'({ahi_q, alo_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            ahi_q   <= '0;
            alo_q   <= '0;
            pdat_q  <= '0;
            pmode_q <= 1'b0;
            func_q  <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_AHI:  ahi_q   <= bus_wdata[7:0];
                OFS_ALO:  alo_q   <= bus_wdata[7:0];
                OFS_PDAT: pdat_q  <= bus_wdata[7:0];
                OFS_PMOD: pmode_q <= bus_wdata[0];
                OFS_FUNC: func_q  <= bus_wdata[1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_PWR:  bus_rdata = {31'd0, pd};
            OFS_AHI:  bus_rdata = {24'd0, ahi_q};
            OFS_ALO:  bus_rdata = {24'd0, alo_q};
            OFS_PDAT: bus_rdata = {24'd0, pdat_q};
            OFS_PMOD: bus_rdata = {31'd0, pmode_q};
            OFS_RDAT: bus_rdata = {24'd0, rbyte};
            OFS_FUNC: bus_rdata = {30'd0, func_q};
            OFS_GO:   bus_rdata = {31'd0, go_pend};
            OFS_RES:  bus_rdata = pack_verdict(verdict);
            OFS_STAT: bus_rdata = {30'd0, settling, busy};
            default:  bus_rdata = '0;
        endcase
    end

    otpc_power #(.SETTLE_CYC(SETTLE_CYC)) u_power (
        .clk(clk), .rst(rst), .wr_i(wr_pwr), .pd_i(bus_wdata[0]),
        .pd_o(pd), .settling_o(settling)
    );

    otpc_seq #(
        .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS),
        .RD_LOCK(RD_LOCK), .WR_LOCK(WR_LOCK), .BUSY_CYC(BUSY_CYC)
    ) u_seq (
        .clk(clk), .rst(rst), .go_wr_i(wr_go), .pwr_ok_i(!pd && !settling),
        .func_i(func_q), .byte_mode_i(pmode_q), .addr_i(req_addr),
        .pdata_i(pdat_q), .arr_rbyte_i(arr_rbyte),
        .go_pend_o(go_pend), .busy_o(busy), .verdict_o(verdict),
        .rbyte_o(rbyte), .arr_addr_o(arr_addr), .arr_we_o(arr_we),
        .arr_wbyte_o(arr_wbyte)
    );

    otpc_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst(rst), .addr_i(arr_addr), .we_i(arr_we),
        .wbyte_i(arr_wbyte), .rbyte_o(arr_rbyte)
    );
endmodule

// File: rtl/otpc_checker.sv
module otpc_checker
    import otpc_pkg::*;
#(
    parameter int                     ADDR_W      = 13,
    parameter int                     NUM_REGIONS = 8,
    parameter logic [NUM_REGIONS-1:0] WR_LOCK     = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              go_pend,
    input logic              busy,
    input logic              pd,
    input logic              settling,
    input verdict_t          verdict,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr
);
    localparam int RGN_W = $clog2(NUM_REGIONS);

    assert_go_accept_R3: assert property (@(posedge clk) disable iff (rst)
        (go_pend && !busy) |=> (busy && !go_pend));

    assert_verdict_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (go_pend && !busy) |=> (verdict == '0));

    assert_single_flag_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(verdict));

    assert_no_locked_prog_R8: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> !WR_LOCK[arr_addr[ADDR_W-1 -: RGN_W]]);

    assert_settle_start_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(settling) |-> (!pd && $past(pd)));

    assert_go_ignored_busy_R12: assert property (@(posedge clk) disable iff (rst)
        (busy && !go_pend) |=> !go_pend);

    assert_prog_only_busy_R5: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> busy);
endmodule

bind otpc_top otpc_checker #(
    .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS), .WR_LOCK(WR_LOCK)
) u_chk (
    .clk(clk), .rst(rst), .go_pend(go_pend), .busy(busy), .pd(pd),
    .settling(settling), .verdict(verdict), .arr_we(arr_we), .arr_addr(arr_addr)
);

// File: tb/otpc_top_test.sv
module otpc_top_test;
    localparam int SETTLE = 6;
    localparam int BUSY   = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    typedef struct {
        string       tag;
        logic [31:0] val;
    } exp_t;
    exp_t expq[$];

    logic [7:0] model [int];

    always #10 clk = ~clk;

    otpc_top #(
        .ADDR_W(13), .NUM_REGIONS(8), .RD_LOCK(8'h80), .WR_LOCK(8'h40),
        .SETTLE_CYC(SETTLE), .BUSY_CYC(BUSY)
    ) uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [7:0] mget(int a);
        return model.exists(a) ? model[a] : 8'h00;
    endfunction

    task automatic expect_item(string tag, logic [31:0] v);
        exp_t e;
        e.tag = tag;
        e.val = v;
        expq.push_back(e);
    endtask

    task automatic monitor(logic [31:0] act);
        exp_t e;
        e = expq.pop_front();
        n_cmp++;
        if (act !== e.val) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", e.tag, act, e.val);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic chk(string tag, logic [7:0] a, logic [31:0] v);
        logic [31:0] d;
        expect_item(tag, v);
        rd(a, d);
        monitor(d);
    endtask

    task automatic wait_done();
        logic [31:0] d;
        for (int n = 0; n < 200; n++) begin
            rd(8'h30, d);
            if (!d[0]) begin
                rd(8'h28, d);
                if (!d[0]) return;
            end
            @(negedge clk);
        end
    endtask

    task automatic set_addr(logic [15:0] a);
        wr(8'h04, {24'd0, a[15:8]});
        wr(8'h08, {24'd0, a[7:0]});
    endtask

    task automatic op_read(logic [15:0] a);
        set_addr(a);
        wr(8'h20, 32'd1);
        wr(8'h28, 32'd1);
        wait_done();
    endtask

    task automatic op_prog(logic [15:0] a, logic [7:0] v, logic mode);
        set_addr(a);
        wr(8'h14, {31'd0, mode});
        wr(8'h10, {24'd0, v});
        wr(8'h20, 32'd2);
        wr(8'h28, 32'd1);
        wait_done();
    endtask

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int busy_n;
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 pwr", 8'h00, 32'd1);
        chk("R1 stat", 8'h30, 32'd0);
        chk("R1 result", 8'h2C, 32'd0);
        chk("R1 go", 8'h28, 32'd0);
        chk("R1 rdata", 8'h18, 32'd0);

        // R9 go while powered down
        op_read(16'h0010);
        chk("R9 powered down fail", 8'h2C, 32'h1);

        // R2 settle window, R9 go during settle
        wr(8'h00, 32'd0);
        chk("R2 settling set", 8'h30, 32'h2);
        wr(8'h28, 32'd1);
        wait_done();
        chk("R9 settling fail", 8'h2C, 32'h1);
        wr(8'h00, 32'd1);
        chk("R2 powerdown clears settle", 8'h30, 32'h0);
        wr(8'h00, 32'd0);
        repeat (SETTLE - 1) @(negedge clk);
        chk("R2 settling last cycle", 8'h30, 32'h2);
        @(negedge clk);
        chk("R2 settling done", 8'h30, 32'h0);

        // R5/R4 program then read
        op_prog(16'h0123, 8'hA5, 1'b1);
        model[16'h0123] = 8'hA5;
        chk("R5 program ok", 8'h2C, 32'h0);
        op_read(16'h0123);
        chk("R4 read result", 8'h2C, 32'h0);
        chk("R4 read data", 8'h18, {24'd0, mget(16'h0123)});

        // R3 go readback and busy length
        set_addr(16'h0123);
        wr(8'h20, 32'd1);
        wr(8'h28, 32'd1);
        chk("R3 go pending", 8'h28, 32'd1);
        @(negedge clk);
        chk("R3 go cleared", 8'h28, 32'd0);
        busy_n = 0;
        for (int k = 0; k < 20; k++) begin
            rd(8'h30, d);
            if (d[0]) busy_n++;
            @(negedge clk);
        end
        expect_item("R3 busy cycles", BUSY);
        monitor(busy_n);

        // R5 OR semantics
        op_prog(16'h0123, 8'h5A, 1'b1);
        model[16'h0123] = mget(16'h0123) | 8'h5A;
        op_prog(16'h0124, 8'h30, 1'b1);
        op_prog(16'h0124, 8'h03, 1'b1);
        op_prog(16'h0124, 8'h00, 1'b1);
        model[16'h0124] = 8'h33;
        op_read(16'h0124);
        chk("R5 or accumulate", 8'h18, {24'd0, mget(16'h0124)});

        // R6 upper address bits ignored
        op_read(16'hE123);
        chk("R6 alias read", 8'h18, {24'd0, mget(16'h0123)});

        // R7 read lock (region 7), programming it still allowed
        op_prog(16'h1C05, 8'h11, 1'b1);
        chk("R7 prog in read-locked ok", 8'h2C, 32'h0);
        op_read(16'h1C05);
        chk("R7 read denied flag", 8'h2C, 32'h8);
        chk("R7 rdata unchanged", 8'h18, {24'd0, mget(16'h0123)});

        // R10 result cleared by next op
        op_read(16'h0124);
        chk("R10 result cleared", 8'h2C, 32'h0);

        // R8 write lock (region 6)
        op_prog(16'h1805, 8'h77, 1'b1);
        chk("R8 prog denied flag", 8'h2C, 32'h4);
        op_read(16'h1805);
        chk("R8 array unchanged", 8'h18, {24'd0, mget(16'h1805)});

        // R11 invalid function and non-byte mode
        set_addr(16'h0200);
        wr(8'h20, 32'd0);
        wr(8'h28, 32'd1);
        wait_done();
        chk("R11 func 0 fail", 8'h2C, 32'h1);
        wr(8'h20, 32'd3);
        wr(8'h28, 32'd1);
        wait_done();
        chk("R11 func 3 fail", 8'h2C, 32'h1);
        op_prog(16'h0200, 8'hFF, 1'b0);
        chk("R11 mode fail", 8'h2C, 32'h1);
        op_read(16'h0200);
        chk("R11 no access", 8'h18, {24'd0, mget(16'h0200)});

        // R12 go during busy ignored
        set_addr(16'h0123);
        wr(8'h20, 32'd1);
        wr(8'h28, 32'd1);
        @(negedge clk);
        wr(8'h28, 32'd1);
        wait_done();
        repeat (4) @(negedge clk);
        chk("R12 no second busy", 8'h30, 32'h0);
        chk("R12 go idle", 8'h28, 32'h0);

        // R9 after power down
        wr(8'h00, 32'd1);
        op_prog(16'h0300, 8'h01, 1'b1);
        chk("R9 powerdown fail", 8'h2C, 32'h1);
        wr(8'h00, 32'd0);
        repeat (SETTLE + 1) @(negedge clk);
        op_read(16'h0300);
        chk("R9 no access", 8'h18, {24'd0, mget(16'h0300)});

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule